// File: doc/BRIEF.md
# Odd-Weight-Column SEC-DED Decoder

This block decodes one received word of a shortened single-error-correcting, double-error-detecting code in a single registered stage. The code's parity-check matrix is systematic. The first `M = N - K` columns form the identity and guard the check bits. Every remaining column has odd weight of three or more, which gives a minimum distance of four. The block computes the `M`-bit syndrome with one XOR tree per matrix row. It matches the syndrome against every column and looks at the parity of the syndrome weight. From that it chooses one of three outcomes: pass the data through, flip one bit, or ask the far end to send the word again.

The matrix is a constant that is computed at elaboration from `N_BITS` and `K_BITS`. Data columns are taken lightest first. Within a weight class, the greedy choice favours columns whose set rows currently carry the fewest ones, so the row trees stay close to equal depth. The (40,33) and (80,72) shapes are both within the supported range (`M` up to 8, `N` up to 128). A link receiver feeds words in, one per cycle, with a valid strobe. It uses the clean, fixed and retry flags to drive a hybrid correct-or-retransmit scheme.

Top module: `secded_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid`, `out_clean`, `out_fixed` and `out_retry` are all 0 after that edge.
- R2: Results appear exactly one clock after the word is presented: `out_valid` equals the `in_valid` of the previous cycle.
- R3: A received word with all-zero syndrome gives `out_clean` = 1, and `out_data` equals received bits `[N-1:M]`.
- R4: A single flipped data bit (word bit `M+i`) gives `out_fixed` = 1, and `out_data` equals the originally sent data, with data bit `i` restored.
- R5: A single flipped check bit (word bits `[M-1:0]`) gives `out_fixed` = 1, and `out_data` equals received bits `[N-1:M]` unchanged.
- R6: Any nonzero syndrome of even weight (every double error) gives `out_retry` = 1, and `out_data` equals the received data bits with no bit flipped.
- R7: An odd-weight syndrome that equals no column of the matrix gives `out_retry` = 1 and uncorrected data. An odd-weight syndrome that equals column `j` flips word bit `j`.
- R8: Whenever `out_valid` = 1, exactly one of the three flags is 1 (flag order clean, fixed, retry). Whenever `out_valid` = 0, all three flags are 0.
- R9: Matrix column `j < M` is the unit vector with bit `j` set. Every data column is distinct, has odd weight ≥ 3, and the per-row counts of ones differ by at most 2 in the default (40,33) shape.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Received word present this cycle |
| in_word | input | N_BITS | Received word; bits [M-1:0] check bits, bits [N-1:M] data |
| out_valid | output | 1 | Decoded result present |
| out_data | output | K_BITS | Corrected or passed-through data |
| out_clean | output | 1 | Syndrome was zero |
| out_fixed | output | 1 | One bit was corrected |
| out_retry | output | 1 | Uncorrectable; retransmission wanted |

## Verification
The assertions assume that `in_valid` and `in_word` are known (0 or 1) on every clock edge while out of reset, and that `in_valid` is low while reset is held. The bench drives both inputs at the falling edge from reset onward, keeps `in_valid` at 0 during reset and between directed cases, and builds every word from a true codeword before applying its error pattern. This keeps each syndrome fully determined. The error patterns cover every single and double position. Triple and five-bit patterns reach odd syndromes both with and without a matching column.

// File: rtl/secded_pkg.sv
// Shared constants and the elaboration-time matrix builder for the
// odd-weight-column SEC-DED decoder. Assumes M <= 8 and N <= 128.
package secded_pkg;

    localparam int MAXM = 8;
    localparam int MAXN = 128;
    localparam int HW   = MAXM * MAXN;

    // Column j of the matrix lives at bits [j*MAXM +: MAXM].
    typedef logic [HW-1:0] hflat_t;

    // Population count of a small integer.
    function automatic int pop_count(input int v);
        int c;
        c = 0;
        for (int b = 0; b < 16; b++) begin
            if (v[b]) c++;
        end
        return c;
    endfunction

    // Builds [I_m | P']: identity first, then odd-weight columns, lightest
    // weight first, each pick favouring the least-loaded rows.
    function automatic hflat_t build_h(input int m, input int n);
        hflat_t          h;
        logic [255:0]    used;
        int              load [MAXM];
        int              best;
        int              bw;
        int              bc;
        int              w;
        int              c;
        logic [MAXM-1:0] cv;
        h    = '0;
        used = '0;
        for (int r = 0; r < MAXM; r++) load[r] = 0;
        for (int j = 0; j < m; j++) begin
            h[j*MAXM + j] = 1'b1;
            load[j]       = 1;
        end
        for (int j = m; j < n; j++) begin
            best = 0;
            bw   = MAXM + 1;
            bc   = 1 << 30;
            for (int v = 1; v < (1 << m); v++) begin
                w = pop_count(v);
                if ((w % 2 == 1) && (w >= 3) && !used[v]) begin
                    c = 0;
                    for (int r = 0; r < m; r++) begin
                        if (v[r]) c += load[r];
                    end
                    if ((w < bw) || ((w == bw) && (c < bc))) begin
                        best = v;
                        bw   = w;
                        bc   = c;
                    end
                end
            end
            used[best] = 1'b1;
            cv = MAXM'(best);
            for (int r = 0; r < MAXM; r++) begin
                if (cv[r]) load[r]++;
            end
            h[j*MAXM +: MAXM] = cv;
        end
        return h;
    endfunction

endpackage

// File: rtl/secded_syndrome.sv
// Syndrome generator: one XOR tree per matrix row over the received word.
// Assumes HMAT holds a valid matrix of N columns, each M rows tall.
module secded_syndrome
    import secded_pkg::*;
#(
    parameter int     N    = 40,
    parameter int     M    = 7,
    parameter hflat_t HMAT = '0
) (
    input  logic [N-1:0] word,
    output logic [M-1:0] syn
);

    // Row r selects the word bits whose column has a one in row r.
    function automatic logic [N-1:0] row_mask(input int r);
        logic [N-1:0] mk;
        for (int j = 0; j < N; j++) mk[j] = HMAT[j*MAXM + r];
        return mk;
    endfunction

    for (genvar r = 0; r < M; r++) begin : g_row
        localparam logic [N-1:0] MASK = row_mask(r);
        // Parity of the masked word forms syndrome bit r.
        assign syn[r] = ^(word & MASK);
    end

endmodule

// File: rtl/secded_locator.sv
// Column matcher: compares the syndrome to every column in parallel and
// reports which data bit to flip. At most one column can match, since all
// columns are distinct.
module secded_locator
    import secded_pkg::*;
#(
    parameter int     N    = 40,
    parameter int     M    = 7,
    parameter hflat_t HMAT = '0
) (
    input  logic [M-1:0]   syn,
    output logic [N-M-1:0] flip_data,
    output logic           any_hit
);

    logic [N-1:0] hit;

    for (genvar j = 0; j < N; j++) begin : g_col
        localparam logic [M-1:0] COL = HMAT[j*MAXM +: M];
        // Equality comparator for column j.
        assign hit[j] = (syn == COL);
    end

    // Only data-column hits change the data; check-bit hits just count as hits.
    assign flip_data = hit[N-1:M];
    assign any_hit   = |hit;

endmodule

// File: rtl/secded_classify.sv
// Decision logic: zero syndrome -> clean; odd weight with a column hit ->
// correct; anything else nonzero -> retransmit.
module secded_classify #(
    parameter int M = 7
) (
    input  logic [M-1:0] syn,
    input  logic         any_hit,
    output logic         is_clean,
    output logic         do_fix,
    output logic         do_retry
);

    logic odd_weight;

    // Weight parity of the syndrome separates one error from two.
    assign odd_weight = ^syn;
    assign is_clean   = ~|syn;
    assign do_fix     = odd_weight & any_hit;
    assign do_retry   = ~is_clean & ~do_fix;

endmodule

// File: rtl/secded_decoder.sv
// Top level: single registered stage that decodes one word per cycle.
// Assumes in_valid is low during reset and inputs are known when sampled.
module secded_decoder
    import secded_pkg::*;
#(
    parameter int N_BITS = 40,
    parameter int K_BITS = 33
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [N_BITS-1:0] in_word,
    output logic              out_valid,
    output logic [K_BITS-1:0] out_data,
    output logic              out_clean,
    output logic              out_fixed,
    output logic              out_retry
);

    localparam int     M_BITS = N_BITS - K_BITS;
    localparam hflat_t HMAT   = build_h(M_BITS, N_BITS);

    logic [M_BITS-1:0] syn;
    logic [K_BITS-1:0] flip_data;
    logic [K_BITS-1:0] raw_data;
    logic              any_hit;
    logic              is_clean;
    logic              do_fix;
    logic              do_retry;

    assign raw_data = in_word[N_BITS-1:M_BITS];

    secded_syndrome #(.N(N_BITS), .M(M_BITS), .HMAT(HMAT)) i_syn (
        .word (in_word),
        .syn  (syn)
    );

    secded_locator #(.N(N_BITS), .M(M_BITS), .HMAT(HMAT)) i_loc (
        .syn       (syn),
        .flip_data (flip_data),
        .any_hit   (any_hit)
    );

    secded_classify #(.M(M_BITS)) i_cls (
        .syn      (syn),
        .any_hit  (any_hit),
        .is_clean (is_clean),
        .do_fix   (do_fix),
        .do_retry (do_retry)
    );

    // Output register: captures the decision and data for each valid word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_clean <= 1'b0;
            out_fixed <= 1'b0;
            out_retry <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_clean <= in_valid & is_clean;
            out_fixed <= in_valid & do_fix;
            out_retry <= in_valid & do_retry;
            if (in_valid) begin
                out_data <= do_fix ? (raw_data ^ flip_data) : raw_data;
            end
        end
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2
    idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R8
    one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones({out_clean, out_fixed, out_retry}) == 1));
    // R8
    no_flag_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(out_clean | out_fixed | out_retry));
    // R3
    clean_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && syn == '0) |=> (out_clean && out_data == $past(raw_data)));
    // R6
    even_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && syn != '0 && !(^syn)) |=> (out_retry && out_data == $past(raw_data)));
    // R4
    fix_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && do_fix) |=> ($countones(out_data ^ $past(raw_data)) <= 1));
    // R5
    no_data_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && flip_data == '0) |=> (out_data == $past(raw_data)));
    // R7
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> $onehot0(flip_data));

endmodule

// File: tb/test_secded_decoder.sv
// Directed bench: one task per scenario, each checking its own results.
module test_secded_decoder;
    import secded_pkg::*;

    localparam int N = 40;
    localparam int K = 33;
    localparam int M = N - K;
    localparam hflat_t H = build_h(M, N);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [N-1:0] in_word = '0;
    logic         out_valid;
    logic [K-1:0] out_data;
    logic         out_clean;
    logic         out_fixed;
    logic         out_retry;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    secded_decoder #(.N_BITS(N), .K_BITS(K)) i_secded_decoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_clean (out_clean),
        .out_fixed (out_fixed),
        .out_retry (out_retry)
    );

    function automatic logic [M-1:0] col(input int j);
        return H[j*MAXM +: M];
    endfunction

    function automatic logic [M-1:0] syn_of(input logic [N-1:0] w);
        logic [M-1:0] s;
        s = '0;
        for (int j = 0; j < N; j++) if (w[j]) s ^= col(j);
        return s;
    endfunction

    function automatic logic [N-1:0] encode(input logic [K-1:0] d);
        logic [N-1:0] w;
        w = {d, {M{1'b0}}};
        w[M-1:0] = syn_of(w);
        return w;
    endfunction

    function automatic logic [K-1:0] rnd_data();
        return {$urandom, $urandom};
    endfunction

    task automatic check(input string req, input logic ok, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Presents one word and compares flags {clean,fixed,retry} and data.
    task automatic apply(input string req, input logic [N-1:0] w,
                         input logic [2:0] ef, input logic [K-1:0] ed);
        logic [2:0] af;
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        @(negedge clk);
        in_valid = 1'b0;
        af = {out_clean, out_fixed, out_retry};
        check(req, out_valid && af == ef && out_data == ed, "flags/data",
              {out_valid, af, 27'd0, out_data}, {1'b1, ef, 27'd0, ed});
    endtask

    task automatic t_reset();
        // R1
        check("R1", !out_valid && !out_clean && !out_fixed && !out_retry,
              "reset outputs", {out_valid, out_clean, out_fixed, out_retry}, 0);
    endtask

    task automatic t_matrix();
        int ld [M];
        int mx;
        int mn;
        logic ok;
        ok = 1'b1;
        for (int r = 0; r < M; r++) ld[r] = 0;
        for (int j = 0; j < N; j++) begin
            for (int r = 0; r < M; r++) if (col(j)[r]) ld[r]++;
            if (j < M) begin
                if (col(j) != M'(1 << j)) ok = 1'b0;
            end else begin
                if ($countones(col(j)) < 3 || !(^col(j))) ok = 1'b0;
                for (int i = M; i < j; i++) if (col(i) == col(j)) ok = 1'b0;
            end
        end
        mx = 0;
        mn = N;
        for (int r = 0; r < M; r++) begin
            if (ld[r] > mx) mx = ld[r];
            if (ld[r] < mn) mn = ld[r];
        end
        // R9
        check("R9", ok, "column shape", 64'(ok), 1);
        check("R9", (mx - mn) <= 2, "row load spread", 64'(mx - mn), 2);
    endtask

    task automatic t_clean();
        logic [K-1:0] pats [6];
        pats[0] = '0;
        pats[1] = '1;
        pats[2] = {17{2'b10}};
        pats[3] = {17{2'b01}};
        pats[4] = rnd_data();
        pats[5] = K'(1);
        // R3
        for (int p = 0; p < 6; p++) apply("R3", encode(pats[p]), 3'b100, pats[p]);
    endtask

    task automatic t_single();
        logic [K-1:0] d;
        logic [N-1:0] w;
        d = rnd_data();
        w = encode(d);
        for (int b = 0; b < N; b++) begin
            // R4 data bits, R5 check bits
            if (b >= M) apply("R4", w ^ (N'(1) << b), 3'b010, d);
            else        apply("R5", w ^ (N'(1) << b), 3'b010, d);
        end
    endtask

    task automatic t_double();
        logic [K-1:0] d;
        logic [N-1:0] w;
        logic [N-1:0] e;
        d = rnd_data();
        w = encode(d);
        for (int a = 0; a < N; a++) begin
            for (int b = a + 1; b < N; b++) begin
                e = w ^ (N'(1) << a) ^ (N'(1) << b);
                // R6
                apply("R6", e, 3'b001, e[N-1:M]);
            end
        end
    endtask

    task automatic t_odd_multi();
        logic [N-1:0] w;
        logic [N-1:0] e;
        logic [M-1:0] s;
        logic [K-1:0] ed;
        int hitj;
        int a;
        int b;
        int c;
        // Five check bits flipped: weight-5 syndrome matches no column.
        w = encode(rnd_data());
        e = w ^ N'(5'b11111);
        // R7
        apply("R7", e, 3'b001, w[N-1:M]);
        for (int t = 0; t < 60; t++) begin
            w = encode(rnd_data());
            a = $urandom_range(0, N - 1);
            b = (a + 1 + $urandom_range(0, N - 3)) % N;
            c = a;
            while (c == a || c == b) c = $urandom_range(0, N - 1);
            e = w ^ (N'(1) << a) ^ (N'(1) << b) ^ (N'(1) << c);
            s = syn_of(e);
            hitj = -1;
            for (int j = 0; j < N; j++) if (col(j) == s) hitj = j;
            ed = e[N-1:M];
            if (hitj >= M) ed[hitj - M] = ~ed[hitj - M];
            // R7: matched column flips that bit; unmatched requests retry
            apply("R7", e, (hitj >= 0) ? 3'b010 : 3'b001, ed);
        end
    endtask

    task automatic t_idle();
        logic [K-1:0] d;
        d = rnd_data();
        apply("R2", encode(d), 3'b100, d);
        @(negedge clk);
        // R2 and R8: no input, no output valid, no flags
        check("R2", !out_valid, "valid when idle", 64'(out_valid), 0);
        check("R8", !(out_clean | out_fixed | out_retry), "flags when idle",
              {out_clean, out_fixed, out_retry}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_matrix();
        t_clean();
        t_single();
        t_double();
        t_odd_multi();
        t_idle();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule